// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit up-counter peripheral for a small microcontroller, reached over a simple byte-wide register bus. It counts either internal instruction-cycle ticks or rising edges of an external clock pin. The external input can go through a two-stage synchroniser, or take a shorter single-register path for lower latency.

A selectable prescaler divides the chosen input by 1, 2, 4 or 8. A gate can stop counting in both timer and counter modes. The gate is fed from a pin or from a comparator output, and its polarity is selectable, so either the low or the high time of an event can be measured.

When the count wraps from FFFFh to 0000h it sets a sticky overflow flag. An interrupt request is raised only when that flag and three enable bits are all set.

Register map (3-bit address, 8-bit data):

- 0 is the control register:
  - bit 0: run
  - bit 1: external clock select
  - bit 2: skip synchroniser
  - bits 5:4: prescale select
  - bit 6: gate enable
  - bit 7: gate invert
- 1 is the low count byte.
- 2 is the high count byte.
- 3 is the flag register, with the overflow flag in bit 0.
- 4 is the enable register:
  - bit 0: peripheral
  - bit 1: group
  - bit 2: global
- 5 is the gate source register, bit 0: 0 selects the pin, 1 selects the comparator.
- Other addresses read as 0.

Reads are combinational and return live values.

Top module: `gated_tmr16`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: With run set (control bit 0), the external select clear, the gate disabled and prescale code 0, the count rises by one for each clock cycle in which `tick` is high.
- R3: Prescale select codes 0, 1, 2 and 3 in control bits 5:4 make the count advance once per 1, 2, 4 and 8 qualifying input events.
- R4: A bus write to either count byte resets the hidden prescale counter to zero.
- R5: With run clear, the count does not change on input events.
- R6: Advancing from FFFFh yields 0000h and sets the overflow flag (flag register bit 0). The flag stays set until software writes 0 to it.
- R7: `irq` is high exactly when the overflow flag and enable bits 0, 1 and 2 are all set.
- R8: With control bit 6 set, counting happens only while the selected gate source is low (bit 7 clear) or high (bit 7 set). The source is chosen by gate source register bit 0: 0 = `gate_pin`, 1 = `cmp_out`. With bit 6 clear the gate has no effect.
- R9: With control bit 1 set, the count advances on rising edges of `ext_clk` and `tick` is ignored. This holds with control bit 2 clear (synchronised path) and with it set (single-register path).
- R10: In counter mode, no rising edge counts until a falling edge of `ext_clk` has been seen since counter mode was last enabled. A rising edge that occurs while the input is still in its enable-time state is ignored.
- R11: When a bus write to a count byte falls in the same cycle as an increment, the written value is stored and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-cycle tick, one clock wide per tick |
| ext_clk | input | 1 | External count input |
| gate_pin | input | 1 | Gate pin |
| cmp_out | input | 1 | Comparator output, alternative gate source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable around each clock edge. They also assume that the gate sources and `tick` are sampled at the same edge that moves the count, so a closed gate can be judged from the same cycle's inputs. The stimulus changes every input only at falling clock edges. It holds `ext_clk` at each level for four cycles, which keeps edges wider than the synchroniser. It never writes the flag register in the cycle the count wraps, so the set-over-clear ordering is never contested.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL = 3'd0,
      A_CLO  = 3'd1,
      A_CHI  = 3'd2,
      A_FLG  = 3'd3,
      A_IEN  = 3'd4,
      A_GSEL = 3'd5
   } reg_addr_e;

   // control register layout, bit 7 first
   typedef struct packed {
      logic       g_inv;
      logic       g_en;
      logic [1:0] psel;
      logic       spare;
      logic       nosync;
      logic       ext_sel;
      logic       run;
   } ctrl_t;

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   input  logic nosync,
   input  logic arm_en,
   output logic rise_o
);

   logic [SYNC_STAGES-1:0] stage_q;
   logic                   cur;
   logic                   prev_q;
   logic                   armed_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= 1'b0;
               else        stage_q[0] <= ext_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= 1'b0;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign cur = nosync ? stage_q[0] : stage_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q <= cur;
         if (!arm_en)
            armed_q <= 1'b0;
         else if (prev_q && !cur)
            armed_q <= 1'b1;
      end
   end

   assign rise_o = arm_en & armed_q & cur & ~prev_q;

endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
   parameter int PRE_W = 3,
   localparam int SEL_W = $clog2(PRE_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [SEL_W-1:0] psel,
   output logic             fire
);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   assign mask = PRE_W'((1 << psel) - 1);
   assign fire = step & ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clr)
         pre_q <= '0;
      else if (step)
         pre_q <= fire ? '0 : pre_q + 1'b1;
   end

endmodule

// File: rtl/tmr16_gate.sv
module tmr16_gate (
   input  logic gate_pin,
   input  logic cmp_out,
   input  logic src_cmp,
   input  logic inv,
   input  logic en,
   output logic open_o
);

   logic level;

   assign level  = src_cmp ? cmp_out : gate_pin;
   // polarity clear: count while the source is low
   assign open_o = ~en | (level == inv);

endmodule

// File: rtl/gated_tmr16.sv
module gated_tmr16
   import tmr16_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ext_clk,
   input  logic              gate_pin,
   input  logic              cmp_out,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int SEL_W = $clog2(PRE_W + 1);
   localparam int IEN_W = 3;

   generate
      if (DATA_W != $bits(ctrl_t)) begin : g_bad_data
         $error("DATA_W must match the control register width");
      end
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("CNT_W must be two bus bytes");
      end
      if (SEL_W != 2) begin : g_bad_pre
         $error("PRE_W must give a two-bit prescale select");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic [IEN_W-1:0] ien_q;
   logic             gsel_q;

   logic wr_ctrl, wr_lo, wr_hi, wr_flg, wr_ien, wr_gsel, cnt_wr;
   logic ext_rise, gate_open, step, fire, inc, wrap;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_lo   = bus_wr && (bus_addr == A_CLO);
   assign wr_hi   = bus_wr && (bus_addr == A_CHI);
   assign wr_flg  = bus_wr && (bus_addr == A_FLG);
   assign wr_ien  = bus_wr && (bus_addr == A_IEN);
   assign wr_gsel = bus_wr && (bus_addr == A_GSEL);
   assign cnt_wr  = wr_lo | wr_hi;

   tmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .ext_in (ext_clk),
      .nosync (ctrl_q.nosync),
      .arm_en (ctrl_q.run & ctrl_q.ext_sel),
      .rise_o (ext_rise)
   );

   tmr16_gate u_gate (
      .gate_pin (gate_pin),
      .cmp_out  (cmp_out),
      .src_cmp  (gsel_q),
      .inv      (ctrl_q.g_inv),
      .en       (ctrl_q.g_en),
      .open_o   (gate_open)
   );

   assign step = ctrl_q.run & gate_open & (ctrl_q.ext_sel ? ext_rise : tick);

   tmr16_presc #(.PRE_W(PRE_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_wr),
      .step  (step),
      .psel  (ctrl_q.psel),
      .fire  (fire)
   );

   assign inc  = fire & ~cnt_wr;
   assign wrap = inc & (cnt_q == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
         flag_q <= 1'b0;
         ien_q  <= '0;
         gsel_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
         if (wr_ien)  ien_q  <= bus_wdata[IEN_W-1:0];
         if (wr_gsel) gsel_q <= bus_wdata[0];
         if (cnt_wr) begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= bus_wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= bus_wdata;
         end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (wrap)
            flag_q <= 1'b1;
         else if (wr_flg)
            flag_q <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: bus_rdata = ctrl_q;
         A_CLO:  bus_rdata = cnt_q[DATA_W-1:0];
         A_CHI:  bus_rdata = cnt_q[CNT_W-1:DATA_W];
         A_FLG:  bus_rdata = DATA_W'(flag_q);
         A_IEN:  bus_rdata = DATA_W'(ien_q);
         A_GSEL: bus_rdata = DATA_W'(gsel_q);
         default: bus_rdata = '0;
      endcase
   end

   assign irq = flag_q & (&ien_q);

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic              flag,
   input logic [7:0]        ctrl,
   input logic [2:0]        ien,
   input logic              gsel,
   input logic              gate_pin,
   input logic              cmp_out,
   input logic              cnt_wr,
   input logic              bus_wr,
   input logic [2:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              inc
);

   logic gate_closed;
   assign gate_closed = ctrl[6] & ((gsel ? cmp_out : gate_pin) != ctrl[7]);

   // R2: the count moves by at most one step without a bus write
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

   // R5: stopped timer holds its count
   assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[0] && !cnt_wr) |=> $stable(cnt));

   // R6: a wrap leaves zero and a set flag
   assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt == {CNT_W{1'b1}}) |=> (flag && cnt == '0));

   // R7: no request without every enable and the flag
   assert_irq_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag || ien != 3'b111) |-> !irq);

   // R8: a closed gate freezes the count
   assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_closed && !cnt_wr) |=> $stable(cnt));

   // R11: a written low byte lands even if an increment was due
   assert_bus_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1) |=> (cnt[DATA_W-1:0] == $past(bus_wdata)));

endmodule

bind gated_tmr16 tmr16_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .cnt       (cnt_q),
   .flag      (flag_q),
   .ctrl      (ctrl_q),
   .ien       (ien_q),
   .gsel      (gsel_q),
   .gate_pin  (gate_pin),
   .cmp_out   (cmp_out),
   .cnt_wr    (cnt_wr),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .inc       (inc)
);

// File: tb/sim_gated_tmr16.sv
`timescale 1ns/1ps
module sim_gated_tmr16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       ext_clk = 1'b0;
   logic       gate_pin = 1'b0;
   logic       cmp_out = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // scoreboard: kind 0 = read data, kind 1 = irq pin
   int    exp_q[$];
   int    kind_q[$];
   string tag_q[$];
   event  smp_ev;

   always #2 clk = ~clk;

   gated_tmr16 u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ext_clk   (ext_clk),
      .gate_pin  (gate_pin),
      .cmp_out   (cmp_out),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // monitor
   always @(smp_ev) begin
      while (exp_q.size() > 0) begin
         automatic int    e = exp_q.pop_front();
         automatic int    k = kind_q.pop_front();
         automatic string t = tag_q.pop_front();
         automatic int    a = (k == 1) ? int'(irq) : int'(bus_rdata);
         checks++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", t, a, e);
         end
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic check_reg(input logic [2:0] a, input int e, input string t);
      @(negedge clk);
      bus_addr = a;
      #1;
      exp_q.push_back(e); kind_q.push_back(0); tag_q.push_back(t);
      -> smp_ev;
   endtask

   task automatic check_irq(input int e, input string t);
      @(negedge clk);
      #1;
      exp_q.push_back(e); kind_q.push_back(1); tag_q.push_back(t);
      -> smp_ev;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic ext_level(input logic v, input int hold);
      @(negedge clk); ext_clk = v;
      repeat (hold) @(negedge clk);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check_reg(3'd0, 0, "R1 ctrl");
      check_reg(3'd1, 0, "R1 lo");
      check_reg(3'd2, 0, "R1 hi");
      check_reg(3'd3, 0, "R1 flag");
      check_reg(3'd4, 0, "R1 ien");
      check_irq(0, "R1 irq");

      // R2 timer mode
      bus_write(3'd0, 8'h01);
      ticks(5);
      check_reg(3'd1, 5, "R2 five ticks");

      // R5 stopped
      bus_write(3'd0, 8'h00);
      ticks(4);
      check_reg(3'd1, 5, "R5 hold when off");

      // R3 prescale ratios
      bus_write(3'd0, 8'h21); bus_write(3'd1, 8'h00);
      ticks(10);
      check_reg(3'd1, 2, "R3 div4");
      bus_write(3'd0, 8'h31); bus_write(3'd1, 8'h00);
      ticks(16);
      check_reg(3'd1, 2, "R3 div8");
      bus_write(3'd0, 8'h11); bus_write(3'd1, 8'h00);
      ticks(7);
      check_reg(3'd1, 3, "R3 div2");

      // R4 prescaler cleared by count write
      bus_write(3'd0, 8'h21); bus_write(3'd1, 8'h00);
      ticks(3);
      bus_write(3'd1, 8'h00);
      ticks(3);
      check_reg(3'd1, 0, "R4 cleared phase");
      ticks(1);
      check_reg(3'd1, 1, "R4 fourth tick");

      // R6 wrap and sticky flag
      bus_write(3'd0, 8'h00);
      bus_write(3'd1, 8'hFE); bus_write(3'd2, 8'hFF);
      bus_write(3'd0, 8'h01);
      ticks(1);
      check_reg(3'd3, 0, "R6 no flag before wrap");
      ticks(1);
      check_reg(3'd1, 0, "R6 wrap lo");
      check_reg(3'd2, 0, "R6 wrap hi");
      check_reg(3'd3, 1, "R6 flag set");
      ticks(3);
      check_reg(3'd3, 1, "R6 flag sticky");

      // R7 interrupt chain
      bus_write(3'd4, 8'h07); check_irq(1, "R7 all set");
      bus_write(3'd4, 8'h06); check_irq(0, "R7 no periph");
      bus_write(3'd4, 8'h05); check_irq(0, "R7 no group");
      bus_write(3'd4, 8'h03); check_irq(0, "R7 no global");
      bus_write(3'd4, 8'h07);
      bus_write(3'd3, 8'h00);
      check_irq(0, "R7 flag cleared");
      check_reg(3'd3, 0, "R6 software clear");

      // R8 gate
      bus_write(3'd0, 8'h00); bus_write(3'd1, 8'h00); bus_write(3'd2, 8'h00);
      bus_write(3'd5, 8'h00); bus_write(3'd0, 8'h41);
      gate_pin = 1'b1; ticks(4);
      check_reg(3'd1, 0, "R8 pin high blocks");
      gate_pin = 1'b0; ticks(4);
      check_reg(3'd1, 4, "R8 pin low counts");
      bus_write(3'd0, 8'hC1);
      ticks(3);
      check_reg(3'd1, 4, "R8 inverted low blocks");
      gate_pin = 1'b1; ticks(3);
      check_reg(3'd1, 7, "R8 inverted high counts");
      bus_write(3'd5, 8'h01);
      cmp_out = 1'b0; ticks(2);
      check_reg(3'd1, 7, "R8 comparator low blocks");
      cmp_out = 1'b1; ticks(2);
      check_reg(3'd1, 9, "R8 comparator high counts");
      bus_write(3'd0, 8'h01); cmp_out = 1'b0;
      ticks(1);
      check_reg(3'd1, 10, "R8 gate disabled");

      // R9 synced counter, input high at enable
      bus_write(3'd0, 8'h00); bus_write(3'd1, 8'h00);
      ext_level(1'b1, 4);
      bus_write(3'd0, 8'h03);
      ticks(3);
      check_reg(3'd1, 0, "R9 tick ignored");
      ext_level(1'b0, 4); ext_level(1'b1, 4);
      ext_level(1'b0, 4); ext_level(1'b1, 6);
      check_reg(3'd1, 2, "R9 synced rises");

      // R10 input low at enable: first rise ignored
      bus_write(3'd0, 8'h00); bus_write(3'd1, 8'h00);
      ext_level(1'b0, 4);
      bus_write(3'd0, 8'h03);
      ext_level(1'b1, 4);
      check_reg(3'd1, 0, "R10 unarmed rise");
      ext_level(1'b0, 4); ext_level(1'b1, 6);
      check_reg(3'd1, 1, "R10 armed rise");

      // R9 unsynchronised path, R10 arming there too
      bus_write(3'd0, 8'h00); bus_write(3'd1, 8'h00);
      ext_level(1'b0, 4);
      bus_write(3'd0, 8'h07);
      ext_level(1'b1, 4); ext_level(1'b0, 4); ext_level(1'b1, 6);
      check_reg(3'd1, 1, "R10 nosync armed");
      ext_level(1'b0, 4); ext_level(1'b1, 6);
      check_reg(3'd1, 2, "R9 nosync rises");

      // R11 bus write beats increment
      bus_write(3'd0, 8'h01); bus_write(3'd1, 8'h10); bus_write(3'd2, 8'h00);
      @(negedge clk);
      tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h40;
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0;
      check_reg(3'd1, 8'h40, "R11 low write wins");
      @(negedge clk);
      tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h12;
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0;
      check_reg(3'd1, 8'h40, "R11 no increment on high write");
      check_reg(3'd2, 8'h12, "R11 high write stored");

      repeat (2) @(negedge clk);
      done = 1'b1;
      report();
   end

endmodule